// File: doc/BRIEF.md
# Serial Converter Digital Core

This block is the digital side of a low-power 8-bit converter that reports its results over a serial port. A single convert-start input does three jobs. Its rising edge wakes the core. Its falling edge freezes the sample and starts a timed conversion. Its level at the end of the conversion decides whether the core stays awake or drops back to sleep. A parallel sample input stands in for the analog front end, so the whole block stays synthesizable. The value present on that input at the falling edge becomes the conversion result.

Results leave through an output shift register clocked by an external serial clock. The shift register is loaded at the end of each conversion. If a serial read is running at that moment, the load waits until the read completes, so a read never mixes bits from two results. A busy flag, an awake indicator and a one-cycle error pulse report progress. The error pulse flags a premature conversion request. All inputs are synchronous to `clk_i`.

Top module: `sadc_core`

## Requirements
- R1: While `rst_ni` is low and after its release, `awake_o`, `busy_o`, `early_err_o` and `ser_data_o` are all 0, and the core is powered down.
- R2: A rising edge on `start_i` in the powered-down state begins power-up. `awake_o` rises exactly PWRUP_CYC clock edges after the first edge that samples `start_i` high.
- R3: A falling edge on `start_i` while awake captures `sample_i` and starts a conversion. `busy_o` is 1 from the next edge on and, with no read in progress, falls exactly CONV_CYC edges after the edge that samples the fall.
- R4: At the final conversion edge, a high `start_i` keeps `awake_o` at 1. A low `start_i` clears `awake_o` at that same edge.
- R5: Until the first rising edge of `start_i` after reset, the serial port is closed: `ser_data_o` stays 0 and `ser_clk_i` is ignored.
- R6: `ser_data_o` presents the MSB of the shift register. A read starts at a `ser_clk_i` rising edge. Each `ser_clk_i` falling edge shifts the register one place toward the MSB. The read ends after the eighth falling edge, and every later bit is 0.
- R7: The result is loaded into the shift register at the end of a conversion when no read is in progress. A read that starts before the end of a conversion returns the previous result.
- R8: If a read is in progress at the end of a conversion, the load is deferred. `busy_o` stays 1 until the load happens, which is on the edge after the one that samples the read's eighth falling edge.
- R9: A falling edge on `start_i` during power-up is ignored: no conversion starts and the power-up schedule is unchanged. In this case `early_err_o` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Convert-start: rise wakes, fall converts, level at end sets power |
| sample_i | input | DATA_W | Value captured as the conversion result |
| ser_clk_i | input | 1 | Serial read clock |
| ser_data_o | output | 1 | Serial result, MSB first |
| busy_o | output | 1 | Conversion running or result load pending |
| awake_o | output | 1 | Core powered up and ready or converting |
| early_err_o | output | 1 | One-cycle pulse for a convert request during power-up |

## Verification
Conversions are run with sample values that include all-zeros, all-ones, alternating bits and single set MSB or LSB. Because of these values, a stuck, reversed or shifted data path returns a visibly wrong byte. Each sample is paired with either a high or a low `start_i` level at the end of the conversion, which separates the stay-awake and sleep outcomes of the power decision. Reads are placed in three positions: wholly after a conversion, spanning its final edge, and repeated past the eighth bit. These placements distinguish an immediate load, a deferred load and the zero fill. Power-up is probed one edge before and at the ready point, with an early convert request in between.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_PWRUP = 2'd1,
    ST_READY = 2'd2,
    ST_CONV  = 2'd3
  } sadc_state_e;
endpackage

// File: rtl/sadc_edge.sv
module sadc_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
    assign fall_o[g] = ~sig_i[g] & prev_q[g];
  end
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PWRUP_CYC = 75,
  parameter int CONV_CYC  = 200,
  localparam int CNT_MAX  = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_lvl_i,
  input  logic              start_rise_i,
  input  logic              start_fall_i,
  input  logic [DATA_W-1:0] sample_i,
  output sadc_state_e       state_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [CNT_W-1:0] PWRUP_LAST = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST  = CNT_W'(CONV_CYC - 1);

  sadc_state_e       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hold_q;
  logic              err_q;

  assign done_o = (state_q == ST_CONV) && (cnt_q == CONV_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DOWN;
      cnt_q   <= '0;
      hold_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= start_fall_i && (state_q == ST_PWRUP);
      unique case (state_q)
        ST_DOWN: begin
          if (start_rise_i) begin
            state_q <= ST_PWRUP;
            cnt_q   <= '0;
          end
        end
        ST_PWRUP: begin
          if (cnt_q == PWRUP_LAST) begin
            state_q <= ST_READY;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_READY: begin
          if (start_fall_i) begin
            state_q <= ST_CONV;
            cnt_q   <= '0;
            hold_q  <= sample_i;
          end
        end
        ST_CONV: begin
          if (cnt_q == CONV_LAST) begin
            // level of start at the last edge picks the power state
            state_q <= start_lvl_i ? ST_READY : ST_DOWN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_DOWN;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign hold_o  = hold_q;
  assign err_o   = err_q;
endmodule

// File: rtl/sadc_oreg.sv
module sadc_oreg #(
  parameter int DATA_W  = 8,
  localparam int BITS_W = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              ser_data_o,
  output logic              pending_o,
  output logic              active_o
);
  localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(DATA_W - 1);

  logic              port_en_q;
  logic              active_q;
  logic              pending_q;
  logic [BITS_W-1:0] bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] res_q;
  logic              load;
  logic [DATA_W-1:0] load_val;

  assign load     = (done_i | pending_q) & ~active_q;
  assign load_val = done_i ? result_i : res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_en_q <= 1'b0;
      active_q  <= 1'b0;
      pending_q <= 1'b0;
      bit_q     <= '0;
      shreg_q   <= '0;
      res_q     <= '0;
    end else begin
      if (start_rise_i) port_en_q <= 1'b1;
      if (done_i) res_q <= result_i;

      if (done_i && active_q) pending_q <= 1'b1;
      else if (load)          pending_q <= 1'b0;

      if (load) begin
        shreg_q <= load_val;
        bit_q   <= '0;
      end else if (active_q && sclk_fall_i) begin
        shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        bit_q   <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) active_q <= 1'b0;
      end

      if (port_en_q && sclk_rise_i && !active_q) begin
        active_q <= 1'b1;
        bit_q    <= '0;
      end
    end
  end

  assign ser_data_o = port_en_q & shreg_q[DATA_W-1];
  assign pending_o  = pending_q;
  assign active_o   = active_q;
endmodule

// File: rtl/sadc_core.sv
module sadc_core
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PWRUP_CYC = 75,
  parameter int CONV_CYC  = 200,
  localparam int CNT_MAX  = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              ser_clk_i,
  output logic              ser_data_o,
  output logic              busy_o,
  output logic              awake_o,
  output logic              early_err_o
);
  logic [1:0]        rise_w, fall_w;
  sadc_state_e       state_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [DATA_W-1:0] hold_w;
  logic              done_w, pending_w, active_w;

  // bit 0: start, bit 1: serial clock
  sadc_edge #(.W(2)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({ser_clk_i, start_i}),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  sadc_ctrl #(
    .DATA_W    (DATA_W),
    .PWRUP_CYC (PWRUP_CYC),
    .CONV_CYC  (CONV_CYC)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_lvl_i  (start_i),
    .start_rise_i (rise_w[0]),
    .start_fall_i (fall_w[0]),
    .sample_i     (sample_i),
    .state_o      (state_w),
    .cnt_o        (cnt_w),
    .hold_o       (hold_w),
    .done_o       (done_w),
    .err_o        (early_err_o)
  );

  sadc_oreg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_rise_i (rise_w[0]),
    .sclk_rise_i  (rise_w[1]),
    .sclk_fall_i  (fall_w[1]),
    .done_i       (done_w),
    .result_i     (hold_w),
    .ser_data_o   (ser_data_o),
    .pending_o    (pending_w),
    .active_o     (active_w)
  );

  assign awake_o = (state_w == ST_READY) || (state_w == ST_CONV);
  assign busy_o  = (state_w == ST_CONV) || pending_w;
endmodule

// File: rtl/sadc_core_chk.sv
module sadc_core_chk
  import sadc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CONV_CYC = 200,
  parameter int CNT_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input sadc_state_e       state_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [DATA_W-1:0] hold_i,
  input logic              awake_i,
  input logic              busy_i,
  input logic              err_i,
  input logic              active_i
);
  AST_RST_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (!awake_i && !busy_i && !err_i)); // R1

  AST_WAKE_AFTER_PWRUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awake_i) |-> $past(state_i) == ST_PWRUP); // R2

  AST_CONV_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_i) == ST_CONV && state_i != ST_CONV)
      |-> $past(cnt_i) == CNT_W'(CONV_CYC - 1)); // R3

  AST_HOLD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_CONV && $past(state_i) == ST_CONV) |-> $stable(hold_i)); // R3

  AST_LOAD_NOT_MID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(!active_i)); // R8

  AST_ERR_IN_PWRUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $past(state_i) == ST_PWRUP); // R9
endmodule

bind sadc_core sadc_core_chk #(
  .DATA_W   (DATA_W),
  .CONV_CYC (CONV_CYC),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (state_w),
  .cnt_i    (cnt_w),
  .hold_i   (hold_w),
  .awake_i  (awake_o),
  .busy_i   (busy_o),
  .err_i    (early_err_o),
  .active_i (active_w)
);

// File: tb/sim_sadc_core.sv
module sim_sadc_core;
  localparam int PW = 75;
  localparam int CV = 200;

  typedef struct packed {
    logic [7:0] smp;
    logic       keep;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{smp: 8'hA5, keep: 1'b1},
    '{smp: 8'h00, keep: 1'b1},
    '{smp: 8'hFF, keep: 1'b0},
    '{smp: 8'h01, keep: 1'b0},
    '{smp: 8'h80, keep: 1'b1},
    '{smp: 8'h7E, keep: 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] sample = '0;
  logic       sclk = 1'b0;
  logic       sdata, busy, awake, err;
  int         total = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  sadc_core #(.DATA_W(8), .PWRUP_CYC(PW), .CONV_CYC(CV)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .sample_i    (sample),
    .ser_clk_i   (sclk),
    .ser_data_o  (sdata),
    .busy_o      (busy),
    .awake_o     (awake),
    .early_err_o (err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // half: clock cycles per serial half period; last fall followed by one step
  task automatic rd(input int half, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      b[7-i] = sdata;
      sclk = 1'b1;
      step(half);
      sclk = 1'b0;
      step(i == 7 ? 1 : half);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    step(3);
    chk("R1 awake", awake, 0);
    chk("R1 busy", busy, 0);
    chk("R1 err", err, 0);
    chk("R1 data", sdata, 0);
    rst_n = 1'b1;
    step(2);
    chk("R1 awake after release", awake, 0);
    // R5: serial clock before port opens
    rd(1, got);
    chk("R5 closed port", got, 0);

    // R2 power-up boundary
    start = 1'b1;
    step(PW);
    chk("R2 not yet awake", awake, 0);
    step(1);
    chk("R2 awake", awake, 1);

    // first conversion, sleep afterwards
    sample = 8'h3C;
    start  = 1'b0;
    step(1);
    chk("R3 busy start", busy, 1);
    step(CV - 1);
    chk("R3 busy last", busy, 1);
    step(1);
    chk("R3 busy end", busy, 0);
    chk("R4 sleep", awake, 0);
    rd(1, got);
    chk("R6 read", got, 8'h3C);
    rd(1, got);
    chk("R6 zero fill", got, 0);

    // vector walk: sample value x end-of-conversion level
    for (int i = 0; i < 6; i++) begin
      if (!awake) begin
        start = 1'b1;
        step(PW + 2);
      end
      sample = VECS[i].smp;
      start  = 1'b0;
      step(1);
      chk("R3 busy vec", busy, 1);
      step(50);
      if (VECS[i].keep) start = 1'b1;
      step(CV - 50);
      chk("R3 done vec", busy, 0);
      chk("R4 power vec", awake, int'(VECS[i].keep));
      rd(1, got);
      chk("R7 result vec", got, VECS[i].smp);
    end

    // R9: convert request during power-up
    start = 1'b1;
    step(10);
    start = 1'b0;
    step(1);
    chk("R9 err pulse", err, 1);
    step(1);
    chk("R9 err one cycle", err, 0);
    chk("R9 no conversion", busy, 0);
    step(PW - 12);
    chk("R9 schedule before", awake, 0);
    step(1);
    chk("R9 schedule on time", awake, 1);
    step(5);
    chk("R9 still idle", busy, 0);

    // R7/R8: unread result, then read spanning the next conversion end
    start = 1'b1;
    step(1);
    sample = 8'h81;
    start  = 1'b0;
    step(CV + 1);
    chk("R7 first done", busy, 0);
    start = 1'b1;
    step(PW + 2);
    sample = 8'h5A;
    start  = 1'b0;
    step(CV - 10);
    rd(2, got);
    chk("R7 previous result", got, 8'h81);
    chk("R8 busy held", busy, 1);
    step(1);
    chk("R8 busy released", busy, 0);
    chk("R4 sleep deferred", awake, 0);
    rd(1, got);
    chk("R8 deferred load", got, 8'h5A);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule